// File: doc/BRIEF.md
# Dual-Tag Line Directory with Snoop Invalidate

This block holds the tag and valid state for a small cache. Every line stores two tags: the virtual tag used to find hits, and the physical tag of the memory the line holds. A read lookup is direct-mapped on the virtual index. It compares only the virtual tag, so a hit never waits for address translation.

A coherent bus presents physical tags on a snoop port. The snoop tag is compared against the stored physical tag of every line in parallel, whatever the line's index. Every line that matches loses its valid bit. Several virtual lines can alias the same physical memory, and all of those aliases are caught by one snoop.

A fill port writes both tags into one line and sets its valid bit. A flush input clears every valid bit at once. Data storage and replacement policy live outside the block.

Top module: `dual_tag_cache`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every valid bit, so every lookup after reset misses.
- R2: hit_o is 1 in the same cycle when the line selected by lk_idx_i is valid and its stored virtual tag equals lk_vtag_i. Otherwise hit_o is 0. Physical tags play no part in a lookup.
- R3: hit_line_o equals lk_idx_i while hit_o is 1, and it is all zeros while hit_o is 0.
- R4: When fill_i is high at a clock edge, line fill_idx_i stores fill_vtag_i and fill_ptag_i and becomes valid from the next cycle, unless R7 or R8 applies.
- R5: When snoop_i is high at a clock edge, every line whose stored physical tag equals snoop_ptag_i becomes invalid from the next cycle, for any number of lines at any index.
- R6: A snoop leaves every line whose stored physical tag differs from snoop_ptag_i unchanged.
- R7: If a fill and a snoop occur in the same cycle, the filled line ends invalid when snoop_ptag_i equals either the physical tag being filled or the physical tag the line held before.
- R8: When flush_i is high at a clock edge, every line is invalid from the next cycle, including a line being filled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_idx_i | input | IDX_W | Index of the line to look up |
| lk_vtag_i | input | VTAG_W | Virtual tag for the lookup |
| hit_o | output | 1 | The lookup hits |
| hit_line_o | output | IDX_W | Index of the line that hit, zero on a miss |
| fill_i | input | 1 | Write a line |
| fill_idx_i | input | IDX_W | Index of the line to write |
| fill_vtag_i | input | VTAG_W | Virtual tag to store |
| fill_ptag_i | input | PTAG_W | Physical tag to store |
| snoop_i | input | 1 | A snoop tag is present |
| snoop_ptag_i | input | PTAG_W | Physical tag from the coherent bus |
| flush_i | input | 1 | Invalidate all lines |

## Verification
The bench builds the block with 16 lines, 6-bit virtual tags and 4-bit physical tags. The lines are normally 256 and the physical tag 21 bits. The narrow physical tag makes random snoops often match one or several stored lines, so alias invalidation comes up many times rather than almost never. With 16 lines, random fills revisit the same index often enough that fill-and-snoop collisions on one line do occur. The directed part sets up two lines that alias one physical tag and checks that a single snoop removes both.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned DTC_LINES  = 256;
  localparam int unsigned DTC_VTAG_W = 20;
  localparam int unsigned DTC_PTAG_W = 21;

  // next-state action for one line
  typedef enum logic [1:0] {
    LN_KEEP  = 2'd0,
    LN_WRITE = 2'd1,
    LN_KILL  = 2'd2,
    LN_CLEAR = 2'd3
  } line_op_e;
endpackage

// File: rtl/dtc_snoop_match.sv
module dtc_snoop_match #(
  parameter int unsigned LINES  = 256,
  parameter int unsigned PTAG_W = 21
) (
  input  logic                           snoop_i,
  input  logic [PTAG_W-1:0]              snoop_ptag_i,
  input  logic [LINES-1:0][PTAG_W-1:0]   ptag_i,
  output logic [LINES-1:0]               kill_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign kill_o[g] = snoop_i && (ptag_i[g] == snoop_ptag_i);
  end
endmodule

// File: rtl/dtc_tag_array.sv
module dtc_tag_array
  import dtc_pkg::*;
#(
  parameter int unsigned LINES  = 256,
  parameter int unsigned VTAG_W = 20,
  parameter int unsigned PTAG_W = 21,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           fill_i,
  input  logic [IDX_W-1:0]               fill_idx_i,
  input  logic [VTAG_W-1:0]              fill_vtag_i,
  input  logic [PTAG_W-1:0]              fill_ptag_i,
  input  logic                           snoop_i,
  input  logic [PTAG_W-1:0]              snoop_ptag_i,
  input  logic [LINES-1:0]               kill_i,
  input  logic                           flush_i,
  output logic [LINES-1:0]               valid_o,
  output logic [LINES-1:0][VTAG_W-1:0]   vtag_o,
  output logic [LINES-1:0][PTAG_W-1:0]   ptag_o
);
  logic [LINES-1:0]             valid_q;
  logic [LINES-1:0][VTAG_W-1:0] vtag_q;
  logic [LINES-1:0][PTAG_W-1:0] ptag_q;
  logic                         fill_kill;

  // snoop that matches the incoming tag of a fill
  assign fill_kill = snoop_i && (fill_ptag_i == snoop_ptag_i);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_op_e op;
    logic     sel;
    assign sel = fill_i && (fill_idx_i == IDX_W'(g));

    always_comb begin
      if (flush_i)                      op = LN_CLEAR;
      else if (sel)                     op = (kill_i[g] || fill_kill) ? LN_CLEAR : LN_WRITE;
      else if (kill_i[g])               op = LN_KILL;
      else                              op = LN_KEEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 valid_q[g] <= 1'b0;
      else if (op == LN_WRITE)                     valid_q[g] <= 1'b1;
      else if (op == LN_KILL || op == LN_CLEAR)    valid_q[g] <= 1'b0;
    end

    // tags are written on every fill, even one that ends invalid
    always_ff @(posedge clk_i) begin
      if (sel) begin
        vtag_q[g] <= fill_vtag_i;
        ptag_q[g] <= fill_ptag_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign vtag_o  = vtag_q;
  assign ptag_o  = ptag_q;

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  p_snoop_kills_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_i |=> ((valid_q & $past(kill_i)) == '0));

  p_fill_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && !fill_kill && !kill_i[fill_idx_i]) |=> valid_q[$past(fill_idx_i)]);

  p_single_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(valid_q & ~$past(valid_q)) != 0) |->
      ($past(fill_i) && $countones(valid_q & ~$past(valid_q)) == 1));
endmodule

// File: rtl/dtc_lookup.sv
module dtc_lookup #(
  parameter int unsigned LINES  = 256,
  parameter int unsigned VTAG_W = 20,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]               valid_i,
  input  logic [LINES-1:0][VTAG_W-1:0]   vtag_i,
  input  logic [IDX_W-1:0]               lk_idx_i,
  input  logic [VTAG_W-1:0]              lk_vtag_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_line_o
);
  assign hit_o      = valid_i[lk_idx_i] && (vtag_i[lk_idx_i] == lk_vtag_i);
  assign hit_line_o = hit_o ? lk_idx_i : '0;
endmodule

// File: rtl/dual_tag_cache.sv
module dual_tag_cache
  import dtc_pkg::*;
#(
  parameter int unsigned LINES  = DTC_LINES,
  parameter int unsigned VTAG_W = DTC_VTAG_W,
  parameter int unsigned PTAG_W = DTC_PTAG_W,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [VTAG_W-1:0] lk_vtag_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_line_o,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VTAG_W-1:0] fill_vtag_i,
  input  logic [PTAG_W-1:0] fill_ptag_i,
  input  logic              snoop_i,
  input  logic [PTAG_W-1:0] snoop_ptag_i,
  input  logic              flush_i
);
  logic [LINES-1:0]             valid;
  logic [LINES-1:0][VTAG_W-1:0] vtag;
  logic [LINES-1:0][PTAG_W-1:0] ptag;
  logic [LINES-1:0]             kill;

  dtc_snoop_match #(.LINES(LINES), .PTAG_W(PTAG_W)) u_snoop (
    .snoop_i      (snoop_i),
    .snoop_ptag_i (snoop_ptag_i),
    .ptag_i       (ptag),
    .kill_o       (kill)
  );

  dtc_tag_array #(.LINES(LINES), .VTAG_W(VTAG_W), .PTAG_W(PTAG_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_i),
    .fill_idx_i   (fill_idx_i),
    .fill_vtag_i  (fill_vtag_i),
    .fill_ptag_i  (fill_ptag_i),
    .snoop_i      (snoop_i),
    .snoop_ptag_i (snoop_ptag_i),
    .kill_i       (kill),
    .flush_i      (flush_i),
    .valid_o      (valid),
    .vtag_o       (vtag),
    .ptag_o       (ptag)
  );

  dtc_lookup #(.LINES(LINES), .VTAG_W(VTAG_W)) u_lookup (
    .valid_i    (valid),
    .vtag_i     (vtag),
    .lk_idx_i   (lk_idx_i),
    .lk_vtag_i  (lk_vtag_i),
    .hit_o      (hit_o),
    .hit_line_o (hit_line_o)
  );

  p_hit_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_line_o == lk_idx_i));

  p_miss_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_line_o == '0));

  p_hit_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid[lk_idx_i]);
endmodule

// File: tb/tb_dual_tag_cache.sv
module tb_dual_tag_cache;
  localparam int L  = 16;
  localparam int VW = 6;
  localparam int PW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] lk_idx = '0;
  logic [VW-1:0] lk_vtag = '0;
  logic          hit;
  logic [IW-1:0] hit_line;
  logic          fill = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic [VW-1:0] fill_vtag = '0;
  logic [PW-1:0] fill_ptag = '0;
  logic          snoop = 1'b0;
  logic [PW-1:0] snoop_ptag = '0;
  logic          flush = 1'b0;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_v[L], m_vt[L], m_pt[L];

  always #10 clk = ~clk;

  dual_tag_cache #(.LINES(L), .VTAG_W(VW), .PTAG_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_idx_i(lk_idx), .lk_vtag_i(lk_vtag),
    .hit_o(hit), .hit_line_o(hit_line),
    .fill_i(fill), .fill_idx_i(fill_idx), .fill_vtag_i(fill_vtag), .fill_ptag_i(fill_ptag),
    .snoop_i(snoop), .snoop_ptag_i(snoop_ptag), .flush_i(flush)
  );

  task automatic step(input bit f, input int fi, input int fv, input int fp,
                      input bit s, input int sp, input bit fl,
                      input int li, input int lv, input string rq);
    bit eh; int el; int old_pt[L];
    @(negedge clk);
    fill = f; fill_idx = IW'(fi); fill_vtag = VW'(fv); fill_ptag = PW'(fp);
    snoop = s; snoop_ptag = PW'(sp); flush = fl;
    lk_idx = IW'(li); lk_vtag = VW'(lv);
    #2;
    eh = (m_v[li] != 0) && (m_vt[li] == lv);
    el = eh ? li : 0;
    n_run++;
    if (hit !== eh || int'(hit_line) !== el) begin
      n_fail++;
      $display("FAIL %s: hit=%0b line=%0d expected hit=%0b line=%0d", rq, hit, hit_line, eh, el);
    end
    @(posedge clk);
    old_pt = m_pt;
    for (int i = 0; i < L; i++) begin
      if (fl) m_v[i] = 0;
      else if (f && i == fi) begin
        m_vt[i] = fv; m_pt[i] = fp;
        m_v[i] = (s && (sp == fp || sp == old_pt[i])) ? 0 : 1;
      end else if (s && old_pt[i] == sp) m_v[i] = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < L; i++) begin m_v[i] = 0; m_vt[i] = 0; m_pt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < L; i++) step(0, 0, 0, 0, 0, 0, 0, i, 0, "R1");

    // R4 fill then hit; R2 wrong vtag misses
    step(1, 3, 5, 9, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 3, 5, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 3, 6, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 4, 5, "R2");

    // R5 two aliases of ptag 9, R6 unrelated line survives
    step(1, 7, 1, 9, 0, 0, 0, 0, 0, "R4");
    step(1, 12, 2, 2, 0, 0, 0, 7, 1, "R4");
    step(0, 0, 0, 0, 1, 9, 0, 3, 5, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 3, 5, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 7, 1, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 12, 2, "R6");

    // R7 collisions: new ptag match, old ptag match
    step(1, 5, 2, 4, 1, 4, 0, 12, 2, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 5, 2, "R7");
    step(1, 12, 3, 8, 1, 2, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 12, 3, "R7");

    // R8 flush overrides a fill
    step(1, 1, 7, 3, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 8, 5, 0, 0, 0, 1, 7, "R4");
    step(1, 9, 9, 6, 0, 0, 1, 2, 8, "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, (i == 0) ? 1 : (i == 1) ? 2 : 9, 7 + i, "R8");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int li = $urandom_range(0, L - 1);
      int lv = (k % 3 == 0) ? $urandom_range(0, 63) : m_vt[li];
      step($urandom_range(0, 1) == 1, $urandom_range(0, L - 1), $urandom_range(0, 63),
           $urandom_range(0, 15), $urandom_range(0, 3) == 0, $urandom_range(0, 15),
           $urandom_range(0, 40) == 0, li, lv, "R2 R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule